// File: doc/BRIEF.md
# Register-Controlled PWM with Staged Phase Counts

This block generates a single pulse-width-modulated output. The waveform is described by two independent counts measured in input clock cycles: how long the output stays in its active state, and how long it then stays inactive. One period is the active stretch followed by the inactive stretch, so its length is the sum of the two counts.

Software reaches the block through a small 32-bit register bus made of a write strobe, a byte address, write data and combinational read data. Writes to the two count registers are held in staging copies. The running waveform keeps using its previous counts until a control write carrying the commit bit loads both staged counts together. That commit also restarts the period at the beginning of the active stretch. The control register also holds a run bit, a drive bit and a polarity-swap bit. Two spare bits are stored and read back but do not change the waveform.

Top module: `shadowed_pwm`

## Requirements
- R1: After reset every register reads 0 and `pwmOut` is low.
- R2: A write to the active-count register (byte address 0x1C) or the inactive-count register (0x18) changes only the staged copy. The waveform keeps using the previously committed counts until a commit.
- R3: A write to the control register (0x00) with bit 5 set copies both staged counts into the running counts in the same cycle. The cycle right after that write edge is the first cycle of the active stretch.
- R4: While running, each period consists of exactly the committed active count of cycles at the active level, followed by exactly the committed inactive count of cycles at the inactive level, and then repeats.
- R5: With an active count of 0 the output stays at the inactive level. With an inactive count of 0 and a nonzero active count it stays at the active level. With both counts at 0 it stays at the inactive level.
- R6: The waveform runs only while both control bit 0 (run) and control bit 14 (drive) are 1. Otherwise the output sits at the inactive level and the period is held at its start, so writing 0 to the control register stops the output.
- R7: Control bit 10 swaps the polarity after the run/drive gating: the active level becomes low, and a stopped channel drives high.
- R8: Reads return the staged count at 0x18 and 0x1C and the stored control bits at 0x00, with bit 5 always reading 0. Any other address reads 0.
- R9: Control bits 2 and 9 are stored and read back but have no effect on the waveform. A control write without bit 5 does not disturb a running period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the counts are measured in its cycles |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe for the register bus |
| busAddr | input | 8 | Byte address for reads and writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| pwmOut | output | 1 | Modulated output |

## Verification
The waveform is tried with unequal counts (3 active, 5 inactive), with equal short counts (2 and 2), and with each count set to 0 and with both set to 0. This shows whether the two stretches are sized from the correct registers, and whether the zero cases bypass a stretch instead of adding a stray cycle to it. Staged counts are written while the old pattern is still running, so a design that applies them early breaks the expected phase. Control writes without the commit bit are issued in the middle of a period; this separates a correct design from one that restarts on any control write. The polarity bit is tried both while running and while stopped, which shows whether the swap is applied after the gating.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  // Register byte addresses
  localparam logic [7:0] ADDR_CTRL = 8'h00;
  localparam logic [7:0] ADDR_LOW  = 8'h18;
  localparam logic [7:0] ADDR_HIGH = 8'h1C;

  // Control bit positions
  localparam int BIT_RUN    = 0;
  localparam int BIT_STYLE  = 2;
  localparam int BIT_COMMIT = 5;
  localparam int BIT_FIRE   = 9;
  localparam int BIT_FLIP   = 10;
  localparam int BIT_DRIVE  = 14;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } spwm_phase_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;  // copy staged counts and restart the period
    logic run;   // run and drive both set
    logic flip;  // swap polarity
  } spwm_strobe_t;

endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
  import spwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [CNT_W-1:0]  stagedHigh,
  output logic [CNT_W-1:0]  stagedLow,
  output spwm_strobe_t      strobe
);

  localparam logic [DATA_W-1:0] COMMIT_MASK = DATA_W'(1) << BIT_COMMIT;

  logic [DATA_W-1:0] ctrlReg;
  logic              hitCtrl, hitLow, hitHigh;

  assign hitCtrl = busAddr == ADDR_W'(ADDR_CTRL);
  assign hitLow  = busAddr == ADDR_W'(ADDR_LOW);
  assign hitHigh = busAddr == ADDR_W'(ADDR_HIGH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      stagedHigh <= '0;
      stagedLow  <= '0;
    end else if (busWe) begin
      if (hitCtrl) ctrlReg    <= busWdata & ~COMMIT_MASK;
      if (hitLow)  stagedLow  <= busWdata[CNT_W-1:0];
      if (hitHigh) stagedHigh <= busWdata[CNT_W-1:0];
    end
  end

  always_comb begin
    strobe.load = busWe && hitCtrl && busWdata[BIT_COMMIT];
    strobe.run  = ctrlReg[BIT_RUN] && ctrlReg[BIT_DRIVE];
    strobe.flip = ctrlReg[BIT_FLIP];
  end

  always_comb begin
    busRdata = '0;
    if (hitCtrl)      busRdata = ctrlReg;
    else if (hitLow)  busRdata = DATA_W'(stagedLow);
    else if (hitHigh) busRdata = DATA_W'(stagedHigh);
  end

  // R8: a count written at an address is what that address reads next cycle
  assert_staged_readback_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && hitLow) |=> (!hitLow || busRdata == DATA_W'($past(busWdata[CNT_W-1:0]))));

  // R8: the commit bit never reads back
  assert_commit_reads_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && hitCtrl) |=> (!hitCtrl || busRdata == ($past(busWdata) & ~COMMIT_MASK)));

endmodule

// File: rtl/spwm_wave.sv
module spwm_wave
  import spwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] stagedHigh,
  input  logic [CNT_W-1:0] stagedLow,
  input  spwm_strobe_t     strobe,
  output logic             pwmOut
);

  logic [CNT_W-1:0] activeHigh, activeLow, cnt;
  spwm_phase_e      phase;
  logic             startHigh, bothZero, lastCycle;

  assign startHigh = strobe.load ? (stagedHigh != '0) : (activeHigh != '0);
  assign bothZero  = (activeHigh == '0) && (activeLow == '0);
  assign lastCycle = (phase == PH_HIGH) ? (cnt == activeHigh - 1'b1)
                                        : (cnt == activeLow - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeHigh <= '0;
      activeLow  <= '0;
      cnt        <= '0;
      phase      <= PH_LOW;
    end else begin
      if (strobe.load) begin
        activeHigh <= stagedHigh;
        activeLow  <= stagedLow;
      end
      if (strobe.load || !strobe.run) begin
        cnt   <= '0;
        phase <= startHigh ? PH_HIGH : PH_LOW;
      end else if (!bothZero) begin
        if (lastCycle) begin
          cnt <= '0;
          if (phase == PH_HIGH) phase <= (activeLow != '0) ? PH_LOW : PH_HIGH;
          else                  phase <= (activeHigh != '0) ? PH_HIGH : PH_LOW;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign pwmOut = (strobe.run && phase == PH_HIGH) ^ strobe.flip;

  // R2: running counts change only on a commit
  assert_staged_isolated_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(activeHigh) && $stable(activeLow)));

  // R3: a commit restarts the period
  assert_commit_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cnt == '0 && (phase == PH_HIGH) == (activeHigh != '0)));

  // R4: the counter never runs past the active stretch
  assert_high_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH) |-> (cnt < activeHigh));

  // R5: a zero active count never reaches the active phase
  assert_zero_high_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (activeHigh == '0) |-> (phase == PH_LOW));

endmodule

// File: rtl/shadowed_pwm.sv
module shadowed_pwm
  import spwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              pwmOut
);

  logic [CNT_W-1:0] stagedHigh, stagedLow;
  spwm_strobe_t     strobe;

  spwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
    .clk        (clk),
    .rstN       (rstN),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .stagedHigh (stagedHigh),
    .stagedLow  (stagedLow),
    .strobe     (strobe)
  );

  spwm_wave #(.CNT_W(CNT_W)) i_wave (
    .clk        (clk),
    .rstN       (rstN),
    .stagedHigh (stagedHigh),
    .stagedLow  (stagedLow),
    .strobe     (strobe),
    .pwmOut     (pwmOut)
  );

endmodule

// File: tb/test_shadowed_pwm.sv
`timescale 1ns/1ps
module test_shadowed_pwm;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWe;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        pwmOut;

  int checkCount = 0;
  int failCount  = 0;

  always #4 clk = ~clk;

  shadowed_pwm i_shadowed_pwm (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  // scoreboard queues
  bit    expQ[$];
  string tagQ[$];

  // reference model state
  logic [31:0] mCtrl, mHigh, mLow, sHigh, sLow;
  longint      mPos;

  function automatic bit modelOut();
    bit run;
    run = mCtrl[0] && mCtrl[14];
    return (run && (mPos < longint'(mHigh))) ^ mCtrl[10];
  endfunction

  task automatic modelAdvance(input bit we, input logic [7:0] a, input logic [31:0] d);
    bit     oldRun;
    longint per;
    oldRun = mCtrl[0] && mCtrl[14];
    per    = longint'(mHigh) + longint'(mLow);
    if (!oldRun) mPos = 0;
    else if (per != 0) mPos = (mPos + 1) % per;
    if (we) begin
      if (a == 8'h00) begin
        mCtrl = d & ~32'h20;
        if (d[5]) begin mHigh = sHigh; mLow = sLow; mPos = 0; end
      end else if (a == 8'h18) sLow = d;
      else if (a == 8'h1C) sHigh = d;
    end
  endtask

  // one cycle, called at a falling edge
  task automatic tick(input bit we, input logic [7:0] a, input logic [31:0] d, input string tag);
    expQ.push_back(modelOut());
    tagQ.push_back(tag);
    busWe = we; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    modelAdvance(we, a, d);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 8'h00, 32'h0, tag);
  endtask

  task automatic readCheck(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busWe = 1'b0; busAddr = a;
    #1;
    checkCount++;
    if (busRdata !== exp) begin
      failCount++;
      $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", tag, a, busRdata, exp);
    end
    @(negedge clk);
    modelAdvance(1'b0, a, 32'h0);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        bit    e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkCount++;
        if (pwmOut !== e) begin
          failCount++;
          $display("FAIL %s: pwmOut=%0b expected %0b at %0t", t, pwmOut, e, $time);
        end
      end
    end
  end

  // watchdog
  initial begin
    #1600000;
    failCount++;
    $display("FAIL R4: watchdog, actual still running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    mCtrl = 0; mHigh = 0; mLow = 0; sHigh = 0; sLow = 0; mPos = 0;
    rstN = 1'b0; busWe = 1'b0; busAddr = 8'h00; busWdata = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    checkCount++;
    if (pwmOut !== 1'b0) begin
      failCount++;
      $display("FAIL R1: pwmOut=%0b expected 0", pwmOut);
    end
    @(negedge clk);
    rstN = 1'b1;
    readCheck(8'h00, 32'h0, "R1");
    readCheck(8'h18, 32'h0, "R1");
    readCheck(8'h1C, 32'h0, "R1");

    // R2 staged writes do not start anything
    tick(1'b1, 8'h1C, 32'd3, "R2");
    tick(1'b1, 8'h18, 32'd5, "R2");
    readCheck(8'h1C, 32'd3, "R8");
    readCheck(8'h18, 32'd5, "R8");
    idle(3, "R2");

    // R3/R4 commit and run 3 high, 5 low
    tick(1'b1, 8'h00, 32'h4021, "R3");
    idle(20, "R4");

    // R2 stage new counts mid-run; old pattern continues
    tick(1'b1, 8'h1C, 32'd2, "R2");
    tick(1'b1, 8'h18, 32'd2, "R2");
    idle(10, "R2");
    tick(1'b1, 8'h00, 32'h4021, "R3");
    idle(12, "R4");

    // R9 spare bits, control write without commit mid-period
    tick(1'b1, 8'h00, 32'h4205, "R9");
    idle(9, "R9");
    readCheck(8'h00, 32'h4205, "R9");
    tick(1'b1, 8'h00, 32'h4225, "R9");
    readCheck(8'h00, 32'h4205, "R8");
    idle(6, "R9");

    // R7 polarity swap while running
    tick(1'b1, 8'h00, 32'h4421, "R7");
    idle(10, "R7");

    // R6/R7 gating
    tick(1'b1, 8'h00, 32'h0400, "R7");
    idle(5, "R7");
    tick(1'b1, 8'h00, 32'h0000, "R6");
    idle(4, "R6");
    tick(1'b1, 8'h00, 32'h0001, "R6");
    idle(4, "R6");
    tick(1'b1, 8'h00, 32'h4000, "R6");
    idle(4, "R6");
    tick(1'b1, 8'h00, 32'h4001, "R6");
    idle(8, "R6");

    // R5 zero counts
    tick(1'b1, 8'h1C, 32'd0, "R5");
    tick(1'b1, 8'h18, 32'd4, "R5");
    tick(1'b1, 8'h00, 32'h4021, "R5");
    idle(10, "R5");
    tick(1'b1, 8'h1C, 32'd3, "R5");
    tick(1'b1, 8'h18, 32'd0, "R5");
    tick(1'b1, 8'h00, 32'h4021, "R5");
    idle(10, "R5");
    tick(1'b1, 8'h1C, 32'd0, "R5");
    tick(1'b1, 8'h00, 32'h4021, "R5");
    idle(8, "R5");

    // R8 unmapped address
    readCheck(8'h04, 32'h0, "R8");
    readCheck(8'h1C, 32'h0, "R8");

    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule